// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Outputs

This block shifts a 32-bit operand left logically, right logically or right arithmetically by a count taken modulo 64. Along with the shifted value it returns the last bit shifted out as a carry flag, and an extend flag that always matches the new carry. When the count is zero, the value passes through unchanged and the caller's previous carry is kept.

An execution stage uses it to produce the data result and the condition-code inputs of a shift instruction in one step. Writing those flags back into a status register is done elsewhere. The datapath is combinational. A parameter can add an output register, which is on by default and gives one cycle of latency.

Top module: `shift_carry_unit`

## Requirements
- R1: Only the low 6 bits of the 8-bit `amount` input are used. For example, amounts 64 and 0 give identical results, and so do 160 and 32.
- R2: With an effective count of 0, `dout` equals `din` and `carry` equals `carry_in`, whatever the operation.
- R3: A logical left shift (`op` = 2'b00) by n from 1 to 31 gives `din << n` with carry equal to `din[32-n]`.
- R4: A right shift by n from 1 to 31 sets carry to `din[n-1]`. A logical right shift (`op` = 2'b01) fills with zeros. An arithmetic right shift (`op` = 2'b10) fills with copies of `din[31]`.
- R5: A shift by exactly 32 gives a result of 0 for both logical operations. The carry is `din[0]` for a left shift and `din[31]` for a right shift.
- R6: A logical shift in either direction by 33 to 63 gives a result of 0 and a carry of 0.
- R7: An arithmetic right shift by 32 to 63 gives 32 copies of `din[31]`, with carry equal to `din[31]`.
- R8: `xflag` equals `carry` on every cycle.
- R9: `op` = 2'b11 behaves exactly like an arithmetic right shift.
- R10: While `rst_n` is low, the registered outputs are 0.
- R11: With `REG_OUT` = 1 (the default), outputs appear one clock after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 32 | Operand |
| amount | input | 8 | Shift count; bits 5:0 used |
| op | input | 2 | 00 left logical, 01 right logical, 10/11 right arithmetic |
| carry_in | input | 1 | Previous carry flag |
| dout | output | 32 | Shifted result |
| carry | output | 1 | New carry |
| xflag | output | 1 | New extend flag, equal to carry |

## Verification
Embedded properties check several rules on every cycle: extend equals carry, a zero count passes the operand and the old carry through, long logical shifts clear both result and carry, and long arithmetic shifts give a sign-filled word whose carry is the sign. The exact carry bit picked for counts 1 to 31, the boundary at a count of 32, the folding of counts above 63 and the aliasing of op 11 are shown only by the bench. It compares random and directed vectors against its own reference model.

// File: rtl/shift_carry_unit.sv
module shift_carry_unit #(
  parameter int WIDTH   = 32,
  parameter int CNT_W   = 6,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amount,
  input  logic [1:0]       op,
  input  logic             carry_in,
  output logic [WIDTH-1:0] dout,
  output logic             carry,
  output logic             xflag
);
  localparam int EXT_W = WIDTH + 1;

  logic [CNT_W-1:0] n;
  logic [EXT_W-1:0] left_ext, right_ext;
  logic             is_left, is_arith;
  logic [WIDTH-1:0] res_c;
  logic             cy_c;

  assign n        = amount[CNT_W-1:0];
  assign is_left  = (op == 2'b00);
  assign is_arith = op[1];

  assign left_ext  = {1'b0, din} << n;
  assign right_ext = is_arith ? EXT_W'($signed({din, 1'b0}) >>> n)
                              : ({din, 1'b0} >> n);

  always_comb begin
    if (n == '0) begin
      res_c = din;
      cy_c  = carry_in;
    end else if (is_left) begin
      res_c = left_ext[WIDTH-1:0];
      cy_c  = left_ext[WIDTH];
    end else begin
      res_c = right_ext[WIDTH:1];
      cy_c  = right_ext[0];
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          dout  <= '0;
          carry <= 1'b0;
        end else begin
          dout  <= res_c;
          carry <= cy_c;
        end
      end

      a_r2_zero_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (amount[CNT_W-1:0] == '0) |=> (dout == $past(din) && carry == $past(carry_in)));

      a_r6_long_logical_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op[1] == 1'b0 && amount[CNT_W-1:0] > CNT_W'(WIDTH)) |=> (dout == '0 && !carry));

      a_r7_long_arith_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (op[1] && amount[CNT_W-1:0] >= CNT_W'(WIDTH))
        |=> (carry == $past(din[WIDTH-1]) && dout == {WIDTH{$past(din[WIDTH-1])}}));

      a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (dout == '0 && !carry));
    end else begin : g_comb
      assign dout  = res_c;
      assign carry = cy_c;
    end
  endgenerate

  assign xflag = carry;

  a_r8_ext_matches: assert property (@(posedge clk) disable iff (!rst_n) xflag == carry);
endmodule

// File: tb/shift_carry_unit_test.sv
module shift_carry_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] din = '0;
  logic [7:0]  amount = '0;
  logic [1:0]  op = '0;
  logic        carry_in = 1'b0;
  logic [31:0] dout;
  logic        carry, xflag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  shift_carry_unit uut (.clk(clk), .rst_n(rst_n), .din(din), .amount(amount),
                        .op(op), .carry_in(carry_in), .dout(dout),
                        .carry(carry), .xflag(xflag));

  always #10 clk = ~clk;

  function automatic logic [32:0] model(input logic [31:0] v, input logic [7:0] a,
                                        input logic [1:0] o, input logic ci);
    int k;
    logic [31:0] r;
    logic c;
    k = int'(a) % 64;
    if (k == 0) begin r = v; c = ci; end
    else if (o == 2'b00) begin
      if (k < 32) begin r = v << k; c = v[32-k]; end
      else if (k == 32) begin r = '0; c = v[0]; end
      else begin r = '0; c = 1'b0; end
    end else if (o == 2'b01) begin
      if (k < 32) begin r = v >> k; c = v[k-1]; end
      else if (k == 32) begin r = '0; c = v[31]; end
      else begin r = '0; c = 1'b0; end
    end else begin
      if (k < 32) begin
        r = v >> k;
        for (int i = 32 - k; i < 32; i++) r[i] = v[31];
        c = v[k-1];
      end else begin r = {32{v[31]}}; c = v[31]; end
    end
    return {c, r};
  endfunction

  function automatic string tag_of(input logic [7:0] a, input logic [1:0] o);
    int k;
    k = int'(a) % 64;
    if (a > 8'd63) return "R1";
    if (k == 0) return "R2";
    if (o == 2'b11) return "R9";
    if (k < 32) return (o == 2'b00) ? "R3" : "R4";
    if (o[1]) return "R7";
    if (k == 32) return "R5";
    return "R6";
  endfunction

  task automatic apply(input logic [31:0] v, input logic [7:0] a,
                       input logic [1:0] o, input logic ci);
    logic [32:0] e;
    string t;
    din = v; amount = a; op = o; carry_in = ci;
    e = model(v, a, o, ci);
    t = tag_of(a, o);
    @(negedge clk);
    checks++;
    if (dout !== e[31:0] || carry !== e[32]) begin
      errors++;
      $display("FAIL %s R11 din=%h amt=%0d op=%0d: got %h/%b expected %h/%b",
               t, v, a, o, dout, carry, e[31:0], e[32]);
    end
    checks++;
    if (xflag !== carry) begin
      errors++;
      $display("FAIL R8 xflag=%b expected %b", xflag, carry);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    process::self().srandom(32'd1234);
    din = 32'hDEAD_BEEF; amount = 8'd5; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (dout !== '0 || carry !== 1'b0 || xflag !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: got %h/%b expected 0/0", dout, carry);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R2 zero count keeps carry_in
    apply(32'h8000_0001, 8'd0, 2'b00, 1'b1);
    apply(32'h8000_0001, 8'd0, 2'b10, 1'b0);
    // R1 modulo 64
    apply(32'h1234_5678, 8'd64, 2'b01, 1'b1);
    apply(32'h8000_0001, 8'd160, 2'b00, 1'b0);
    apply(32'h4000_0003, 8'd65, 2'b01, 1'b0);
    // R3 / R4 edges
    apply(32'h8000_0000, 8'd1, 2'b00, 1'b0);
    apply(32'h0000_0001, 8'd31, 2'b00, 1'b0);
    apply(32'h0000_0001, 8'd1, 2'b01, 1'b0);
    apply(32'h8000_0000, 8'd31, 2'b01, 1'b0);
    apply(32'hF000_0000, 8'd4, 2'b10, 1'b0);
    // R5 count of 32
    apply(32'h0000_0001, 8'd32, 2'b00, 1'b0);
    apply(32'h8000_0000, 8'd32, 2'b01, 1'b0);
    // R6 long logical
    apply(32'hFFFF_FFFF, 8'd33, 2'b00, 1'b1);
    apply(32'hFFFF_FFFF, 8'd63, 2'b01, 1'b1);
    // R7 long arithmetic
    apply(32'h8000_0000, 8'd32, 2'b10, 1'b0);
    apply(32'h7FFF_FFFF, 8'd63, 2'b10, 1'b1);
    apply(32'h8765_4321, 8'd40, 2'b10, 1'b0);
    // R9 op 11 alias
    apply(32'h8000_0010, 8'd5, 2'b11, 1'b0);
    apply(32'h8000_0000, 8'd50, 2'b11, 1'b0);
    for (int i = 0; i < 400; i++) begin
      rv = $urandom();
      apply(rv, 8'($urandom()), 2'($urandom()), 1'($urandom()));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule